// File: doc/BRIEF.md
# Cascaded Interrupt Status Register

This block collects interrupt causes for an image-processing subsystem into one 32-bit status word. The host reads and writes it over a plain register bus with an address, a write strobe and write data, and gets read data back combinationally. Most status bits are sticky event flags. A single-cycle pulse from a pipeline unit sets the flag, and the host clears it by writing 1 to that bit. Two bits work differently. They summarise a secondary status register held in another unit: one follows the MMU's own status lines, and the other follows an overflow cause register. The host cannot clear either of them through this word.

A small detector watches the raw horizontal and vertical sync inputs, ahead of the capture front end, and raises the top status bit on a rising edge of either line. It stays silent while the capture path runs in embedded-sync mode, because there are no discrete sync wires in that mode. A second 32-bit word, the enable mask, selects which status bits drive the level interrupt line to the processor.

Top module: `casc_irq_stat`

## Requirements
- R1: After reset, the status word (address 0x10) and the enable mask (address 0x14) both read 0, and the interrupt output is low.
- R2: Event bits are bits 24:0 (one per pipeline pulse input) and bit 29 (interconnect error). A pulse sets the bit on the next clock edge. The bit then reads 1 until a status write carries a 1 in that position. A 0 in that position leaves the bit unchanged.
- R3: When a pulse and a clearing write hit the same event bit in the same cycle, the bit ends that cycle at 1.
- R4: Bits 30, 27 and 26 of the status word always read 0, including after a write of all ones.
- R5: Bit 28 reads 1 exactly while any MMU status line is high. Writes to bit 28 do not change it.
- R6: Bit 25 becomes 1 in the cycle after the overflow cause vector is nonzero, and it stays 1 after the vector drops to zero. A write of 1 to bit 25 clears it only while the cause vector is all-zero.
- R7: A rising edge on either raw sync input sets bit 31 three clock edges later. This covers two synchroniser stages and one edge-compare stage. A falling edge sets nothing. Bit 31 then behaves as an event bit, with write-1-to-clear.
- R8: While the embedded-sync mode input is high, sync edges do not set bit 31.
- R9: The interrupt output is high exactly while some status bit is 1 and its enable bit is 1. It follows the status word at the same cycle.
- R10: The enable mask reads back exactly what was last written to it. A read from any address other than 0x10 or 0x14 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_pulse | input | 25 | Pipeline event pulses, one per status bit 24:0 |
| ic_err | input | 1 | Interconnect error pulse (bit 29) |
| mmu_stat | input | 8 | MMU secondary status lines (summarised in bit 28) |
| ovf_src | input | 4 | Overflow cause register contents (gates bit 25) |
| hsync_raw | input | 1 | Raw horizontal sync |
| vsync_raw | input | 1 | Raw vertical sync |
| embed_sync | input | 1 | Embedded-sync capture mode selected |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench targets the cycle where a pulse and a clearing write collide on one bit. A design in which the clear wins would drop a real event there. It checks that bit 25 stays set after a clearing write while its overflow causes are still pending, and that it clears only once the causes are gone. A design that cleared early would hide an overflow that is still live, and one that never cleared would hold the interrupt high forever. Sync edges are tested in both directions and with embedded-sync mode on, which catches a detector that fires on falling edges or ignores the mode. The interrupt line is checked against masked and unmasked bits, and the summary MMU bit is written with 1 to show that the write does not touch it.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

   localparam int unsigned STAT_W   = 32;
   localparam int unsigned EVT_W    = 25;
   localparam int unsigned BIT_SYNC = 31;
   localparam int unsigned BIT_ICE  = 29;
   localparam int unsigned BIT_MMU  = 28;
   localparam int unsigned BIT_OVF  = 25;

   typedef enum logic [1:0] {
      K_EVENT  = 2'd0,
      K_MMU    = 2'd1,
      K_OVF    = 2'd2,
      K_RSVD   = 2'd3
   } bit_kind_e;

   function automatic bit_kind_e kind_of(input int unsigned idx);
      if (idx == BIT_MMU)                         return K_MMU;
      if (idx == BIT_OVF)                         return K_OVF;
      if (idx == 30 || idx == 27 || idx == 26)    return K_RSVD;
      return K_EVENT;
   endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
   parameter int unsigned N_LINES = 2,
   parameter int unsigned STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw_i,
   input  logic               embed_i,
   output logic               pulse_o
);

   logic [N_LINES-1:0] stage_q [STAGES];
   logic [N_LINES-1:0] prev_q;
   logic [N_LINES-1:0] rise;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign rise    = stage_q[STAGES-1] & ~prev_q;
   assign pulse_o = (|rise) & ~embed_i;

endmodule

// File: rtl/stat_cell.sv
module stat_cell #(
   parameter casc_irq_pkg::bit_kind_e KIND = casc_irq_pkg::K_EVENT,
   parameter int unsigned SRC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [SRC_W-1:0] src_i,
   output logic             q_o
);
   import casc_irq_pkg::*;

   generate
      if (KIND == K_EVENT) begin : g_event
         logic q;
         logic unused_src;
         assign unused_src = |src_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_i | (q & ~clr_i);
         end
         assign q_o = q;
      end else if (KIND == K_OVF) begin : g_ovf
         logic q;
         logic src_nz;
         logic clr_ok;
         logic unused_set;
         assign unused_set = set_i;
         assign src_nz = |src_i;
         assign clr_ok = clr_i & ~src_nz;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= src_nz | (q & ~clr_ok);
         end
         assign q_o = q;
      end else if (KIND == K_MMU) begin : g_mmu
         logic unused_ctl;
         assign unused_ctl = set_i | clr_i | clk | rst_n;
         assign q_o = |src_i;
      end else begin : g_rsvd
         logic unused_all;
         assign unused_all = set_i | clr_i | clk | rst_n | (|src_i);
         assign q_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/casc_irq_stat.sv
module casc_irq_stat #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned STAT_OFFS   = 'h10,
   parameter int unsigned ENA_OFFS    = 'h14,
   parameter int unsigned MMU_W       = 8,
   parameter int unsigned OVF_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_we,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [casc_irq_pkg::STAT_W-1:0] bus_wdata,
   output logic [casc_irq_pkg::STAT_W-1:0] bus_rdata,
   input  logic [casc_irq_pkg::EVT_W-1:0]  evt_pulse,
   input  logic                            ic_err,
   input  logic [MMU_W-1:0]                mmu_stat,
   input  logic [OVF_W-1:0]                ovf_src,
   input  logic                            hsync_raw,
   input  logic                            vsync_raw,
   input  logic                            embed_sync,
   output logic                            irq
);
   import casc_irq_pkg::*;

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFFS);
   localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_OFFS);
   localparam int unsigned SRC_W = (MMU_W > OVF_W) ? MMU_W : OVF_W;

   generate
      if (SYNC_STAGES < 1) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (STAT_OFFS == ENA_OFFS) begin : g_chk_overlap
         $error("status and enable offsets collide");
      end
      if ((STAT_OFFS % 4) != 0 || (ENA_OFFS % 4) != 0) begin : g_chk_align
         $error("register offsets must be word aligned");
      end
      if (STAT_OFFS >= (1 << ADDR_W) || ENA_OFFS >= (1 << ADDR_W)) begin : g_chk_fit
         $error("register offsets exceed ADDR_W");
      end
      if (MMU_W < 1 || OVF_W < 1) begin : g_chk_src
         $error("secondary source widths must be nonzero");
      end
   endgenerate

   logic                wr_stat;
   logic                wr_ena;
   logic [STAT_W-1:0]   clr_vec;
   logic [STAT_W-1:0]   set_vec;
   logic [STAT_W-1:0]   stat_q;
   logic [STAT_W-1:0]   ena_q;
   logic                sync_pulse;
   logic [SRC_W-1:0]    mmu_ext;
   logic [SRC_W-1:0]    ovf_ext;

   assign wr_stat = bus_we && (bus_addr == A_STAT);
   assign wr_ena  = bus_we && (bus_addr == A_ENA);
   assign clr_vec = wr_stat ? bus_wdata : '0;
   assign mmu_ext = SRC_W'(mmu_stat);
   assign ovf_ext = SRC_W'(ovf_src);

   sync_edge_det #(
      .N_LINES (2),
      .STAGES  (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   ({vsync_raw, hsync_raw}),
      .embed_i (embed_sync),
      .pulse_o (sync_pulse)
   );

   always_comb begin
      set_vec                = '0;
      set_vec[EVT_W-1:0]     = evt_pulse;
      set_vec[BIT_ICE]       = ic_err;
      set_vec[BIT_SYNC]      = sync_pulse;
   end

   generate
      for (genvar b = 0; b < STAT_W; b++) begin : g_bit
         localparam bit_kind_e KIND = kind_of(b);
         logic [SRC_W-1:0] src_b;
         if (KIND == K_MMU) begin : g_src_mmu
            assign src_b = mmu_ext;
         end else if (KIND == K_OVF) begin : g_src_ovf
            assign src_b = ovf_ext;
         end else begin : g_src_none
            assign src_b = '0;
         end
         stat_cell #(
            .KIND  (KIND),
            .SRC_W (SRC_W)
         ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[b]),
            .clr_i (clr_vec[b]),
            .src_i (src_b),
            .q_o   (stat_q[b])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ena_q <= '0;
      else if (wr_ena) ena_q <= bus_wdata;
   end

   assign irq = |(stat_q & ena_q);

   always_comb begin
      if (bus_addr == A_STAT)     bus_rdata = stat_q;
      else if (bus_addr == A_ENA) bus_rdata = ena_q;
      else                        bus_rdata = '0;
   end

endmodule

// File: rtl/casc_irq_stat_chk.sv
module casc_irq_stat_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STAT_OFFS = 'h10,
   parameter int unsigned MMU_W     = 8,
   parameter int unsigned OVF_W     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [24:0]       evt_pulse,
   input logic              ic_err,
   input logic [MMU_W-1:0]  mmu_stat,
   input logic [OVF_W-1:0]  ovf_src,
   input logic              embed_sync,
   input logic              irq,
   input logic [31:0]       stat,
   input logic [31:0]       ena
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFFS);

   logic stat_wr;
   assign stat_wr = bus_we && (bus_addr == A_STAT);

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (stat == 32'h0 && ena == 32'h0));

   a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && bus_wdata[0] && !evt_pulse[0]) |=> !stat[0]);

   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[29] && !(stat_wr && bus_wdata[29])) |=> stat[29]);

   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_err && stat_wr && bus_wdata[29]) |=> stat[29]);

   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_STAT) |-> (bus_rdata[30] == 1'b0 && bus_rdata[27:26] == 2'b00));

   a_r5_mmu_summary: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_STAT) |-> (bus_rdata[28] == (mmu_stat != '0)));

   a_r6_ovf_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_src != '0) |=> stat[25]);

   a_r8_embed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[31]) |-> !$past(embed_sync));

   a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (ena == 32'h0) |-> !irq);

   a_r9_no_stat_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 32'h0) |-> !irq);

endmodule

bind casc_irq_stat casc_irq_stat_chk #(
   .ADDR_W    (ADDR_W),
   .STAT_OFFS (STAT_OFFS),
   .MMU_W     (MMU_W),
   .OVF_W     (OVF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .evt_pulse  (evt_pulse),
   .ic_err     (ic_err),
   .mmu_stat   (mmu_stat),
   .ovf_src    (ovf_src),
   .embed_sync (embed_sync),
   .irq        (irq),
   .stat       (stat_q),
   .ena        (ena_q)
);

// File: tb/tb_casc_irq_stat.sv
module tb_casc_irq_stat;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_STAT = 8'h10;
   localparam logic [7:0] A_ENA  = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [24:0] evt_pulse = '0;
   logic        ic_err = 1'b0;
   logic [7:0]  mmu_stat = '0;
   logic [3:0]  ovf_src = '0;
   logic        hsync_raw = 1'b0;
   logic        vsync_raw = 1'b0;
   logic        embed_sync = 1'b0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   casc_irq_stat dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
      .ic_err(ic_err), .mmu_stat(mmu_stat), .ovf_src(ovf_src),
      .hsync_raw(hsync_raw), .vsync_raw(vsync_raw), .embed_sync(embed_sync),
      .irq(irq)
   );

   // monitor: pops expected items and compares away from the active edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_irq ? {31'h0, irq} : bus_rdata;
         n_tests++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
         end
      end
   end

   task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.req = req;
      sb_q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic expect_irq(input bit e, input string req);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b1; it.exp = {31'h0, e}; it.req = req;
      sb_q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic pulse_evt(input int idx);
      @(posedge clk); #1;
      evt_pulse[idx] = 1'b1;
      @(posedge clk); #1;
      evt_pulse = '0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      wait_cyc(3);
      #1 rst_n = 1'b1;

      // R1 reset state
      expect_reg(A_STAT, 32'h0, "R1 status after reset");
      expect_reg(A_ENA,  32'h0, "R1 enable after reset");
      expect_irq(1'b0, "R1 irq after reset");

      // R10 enable register and unmapped address
      bus_write(A_ENA, 32'hA5C3_0F1E);
      expect_reg(A_ENA, 32'hA5C3_0F1E, "R10 enable readback");
      expect_reg(8'h20, 32'h0, "R10 unmapped read");
      bus_write(A_ENA, 32'h0);

      // R2 event latch and write-1-to-clear
      pulse_evt(5);
      expect_reg(A_STAT, 32'h0000_0020, "R2 event latched");
      bus_write(A_STAT, 32'h0);
      expect_reg(A_STAT, 32'h0000_0020, "R2 write 0 keeps bit");
      bus_write(A_STAT, 32'h0000_0020);
      expect_reg(A_STAT, 32'h0, "R2 write 1 clears bit");
      @(posedge clk); #1 ic_err = 1'b1;
      @(posedge clk); #1 ic_err = 1'b0;
      expect_reg(A_STAT, 32'h2000_0000, "R2 interconnect error bit");
      bus_write(A_STAT, 32'h2000_0000);
      expect_reg(A_STAT, 32'h0, "R2 interconnect error cleared");

      // R3 set wins over simultaneous clear
      pulse_evt(3);
      @(posedge clk); #1;
      evt_pulse[3] = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h8;
      @(posedge clk); #1;
      evt_pulse = '0; bus_we = 1'b0;
      expect_reg(A_STAT, 32'h0000_0008, "R3 set wins");
      bus_write(A_STAT, 32'hFFFF_FFFF);
      expect_reg(A_STAT, 32'h0, "R3 cleared afterwards");

      // R4 reserved bits
      bus_write(A_STAT, 32'hFFFF_FFFF);
      expect_reg(A_STAT, 32'h0, "R4 reserved read zero");

      // R5 MMU summary
      @(posedge clk); #1 mmu_stat = 8'h04;
      expect_reg(A_STAT, 32'h1000_0000, "R5 mmu summary set");
      bus_write(A_STAT, 32'h1000_0000);
      expect_reg(A_STAT, 32'h1000_0000, "R5 write ignored");
      @(posedge clk); #1 mmu_stat = 8'h00;
      expect_reg(A_STAT, 32'h0, "R5 follows source clear");

      // R6 overflow sticky, gated clear
      @(posedge clk); #1 ovf_src = 4'h2;
      wait_cyc(1);
      expect_reg(A_STAT, 32'h0200_0000, "R6 overflow set");
      bus_write(A_STAT, 32'h0200_0000);
      expect_reg(A_STAT, 32'h0200_0000, "R6 clear blocked while source set");
      @(posedge clk); #1 ovf_src = 4'h0;
      expect_reg(A_STAT, 32'h0200_0000, "R6 sticky after source drop");
      bus_write(A_STAT, 32'h0200_0000);
      expect_reg(A_STAT, 32'h0, "R6 clear after source zero");

      // R7 sync edges
      @(posedge clk); #1 hsync_raw = 1'b1;
      wait_cyc(3);
      expect_reg(A_STAT, 32'h8000_0000, "R7 hsync rising");
      bus_write(A_STAT, 32'h8000_0000);
      @(posedge clk); #1 hsync_raw = 1'b0;
      wait_cyc(4);
      expect_reg(A_STAT, 32'h0, "R7 falling edge ignored");
      @(posedge clk); #1 vsync_raw = 1'b1;
      wait_cyc(3);
      expect_reg(A_STAT, 32'h8000_0000, "R7 vsync rising");
      bus_write(A_STAT, 32'h8000_0000);
      @(posedge clk); #1 vsync_raw = 1'b0;
      wait_cyc(4);

      // R8 embedded-sync mode
      @(posedge clk); #1 embed_sync = 1'b1;
      @(posedge clk); #1 hsync_raw = 1'b1; vsync_raw = 1'b1;
      wait_cyc(4);
      expect_reg(A_STAT, 32'h0, "R8 no sync event in embedded mode");
      @(posedge clk); #1 hsync_raw = 1'b0; vsync_raw = 1'b0;
      wait_cyc(4);
      #1 embed_sync = 1'b0;
      wait_cyc(2);
      expect_reg(A_STAT, 32'h0, "R8 nothing after mode exit");

      // R9 interrupt level and masking
      pulse_evt(7);
      expect_irq(1'b0, "R9 masked bit");
      bus_write(A_ENA, 32'h0000_0080);
      expect_irq(1'b1, "R9 enabled bit");
      bus_write(A_ENA, 32'h0000_0100);
      expect_irq(1'b0, "R9 other enable only");
      bus_write(A_ENA, 32'hFFFF_FFFF);
      bus_write(A_STAT, 32'hFFFF_FFFF);
      expect_irq(1'b0, "R9 all clear");
      @(posedge clk); #1 mmu_stat = 8'h80;
      expect_irq(1'b1, "R9 summary bit drives irq");
      @(posedge clk); #1 mmu_stat = 8'h00;
      expect_irq(1'b0, "R9 irq drops with source");

      wait_cyc(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait_cyc(20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule